// File: doc/BRIEF.md
# DMA Request Sampler with Acknowledge

This block sits between an external, asynchronous, active-low DMA request pin for a single channel and the transfer engine. The pin is captured on every rising edge of the bus clock. The block recognises requests either on a high-to-low transition of the pin or on a low level. Each recognised request raises an internal request pulse. One cycle later it returns a single-cycle acknowledge to the requester. A fixed number of cycles after recognition it issues a start-transfer strobe.

After a request is taken, the block stops sampling. In cycle-steal mode, and in burst mode with level detection, sampling resumes one cycle after the bus controller signals that the first transfer bus cycle has begun. In burst mode with edge detection the pin is looked at only once per block, so the burst produces a single acknowledge, and sampling comes back only when the block-complete strobe arrives. Arbitration between channels and address generation are handled elsewhere.

Top module: `dreq_sampler`

## Requirements
- R1: After reset, with the pin held high, recog_o, start_o and dack_o stay low. The capture stages reset to the high (idle) value, so no falling edge is seen at power-up.
- R2: With det_level_i = 0 (falling-edge detection), recog_o is high in the second cycle after the first rising clock edge that captures the pin low, provided the previous capture was high.
- R3: With det_level_i = 1 (low-level detection), recog_o is high in the cycle that follows the first rising clock edge that captures the pin low.
- R4: recog_o is a one-cycle pulse for each recognised request. dack_o is high for exactly one cycle, in the cycle after each recog_o pulse, in every mode.
- R5: start_o pulses for one cycle exactly START_DLY (default 4) cycles after each recog_o pulse.
- R6: Outside edge-detected burst mode (burst_i = 0, or det_level_i = 1), no further request is recognised after a recognition until bus_start_i is seen high. Sampling is re-armed one cycle after that edge, so a pin that is still low is recognised two cycles after the bus_start_i cycle.
- R7: In burst mode with edge detection (burst_i = 1, det_level_i = 0), only one request is recognised per block. Pin toggles and bus_start_i pulses are ignored until blk_done_i is seen high, and sampling resumes in the following cycle.
- R8: In edge detection, a rising edge, a pin that stays low, and a falling edge that occurs while sampling is disarmed all produce no request.
- R9: In level detection, a pin that stays low produces a new request at each re-arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dreq_ni | input | 1 | Raw asynchronous request pin, active low |
| det_level_i | input | 1 | 1 = low-level detection, 0 = falling-edge detection |
| burst_i | input | 1 | 1 = burst transfer, 0 = cycle-steal transfer |
| bus_start_i | input | 1 | First DMA transfer bus cycle has started |
| blk_done_i | input | 1 | Block transfer complete |
| recog_o | output | 1 | Request-recognised pulse |
| start_o | output | 1 | Start-transfer strobe |
| dack_o | output | 1 | One-cycle acknowledge to the requester |

## Verification
On every cycle, the assertions check the following. Each recognition is a single-cycle pulse with an acknowledge in the next cycle. Every recognition in edge mode traces back to a high-then-low pin history, and every recognition in level mode traces back to a low capture. No recognition appears while a burst block is being held or before the bus-start re-arm. Only the bench's scenarios can show the exact recognition latencies, the distance from recognition to the start strobe, and the behaviours that need a sequence of stimulus: a steady low pin being repeated in level mode but ignored in edge mode, and the re-arm on block completion.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

  // capture, synchronised, previous-synchronised
  localparam int unsigned SYNC_STAGES = 3;

  typedef enum logic [1:0] {
    ST_ARMED    = 2'd0,
    ST_WAIT_BUS = 2'd1,
    ST_REARM    = 2'd2,
    ST_HOLD     = 2'd3
  } arm_state_e;

endpackage

// File: rtl/dreq_sync.sv
module dreq_sync
  import dreq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic cap_o,
  output logic sync_o,
  output logic prev_o
);

  logic [SYNC_STAGES-1:0] chain_q;

  // all stages reset high: idle pin, no spurious falling edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b1;
    else         chain_q[0] <= pin_i;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[i] <= 1'b1;
      else         chain_q[i] <= chain_q[i-1];
    end
  end

  assign cap_o  = chain_q[0];
  assign sync_o = chain_q[1];
  assign prev_o = chain_q[2];

endmodule

// File: rtl/dreq_detect.sv
module dreq_detect (
  input  logic det_level_i,
  input  logic cap_i,
  input  logic sync_i,
  input  logic prev_i,
  output logic hit_o
);

  logic level_hit;
  logic edge_hit;

  assign level_hit = ~cap_i;
  assign edge_hit  = prev_i & ~sync_i;
  assign hit_o     = det_level_i ? level_hit : edge_hit;

endmodule

// File: rtl/dreq_arm_ctrl.sv
module dreq_arm_ctrl
  import dreq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic det_level_i,
  input  logic burst_i,
  input  logic bus_start_i,
  input  logic blk_done_i,
  output logic recog_o
);

  arm_state_e state_q, state_d;
  logic       take;
  logic       once_per_blk;

  assign take         = (state_q == ST_ARMED) & hit_i;
  assign once_per_blk = burst_i & ~det_level_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ARMED:    if (take) state_d = once_per_blk ? ST_HOLD : ST_WAIT_BUS;
      ST_WAIT_BUS: if (bus_start_i) state_d = ST_REARM;
      ST_REARM:    state_d = ST_ARMED;
      ST_HOLD:     if (blk_done_i) state_d = ST_ARMED;
      default:     state_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ARMED;
    else         state_q <= state_d;
  end

  assign recog_o = take;

endmodule

// File: rtl/dreq_pulse_gen.sv
module dreq_pulse_gen #(
  parameter int unsigned START_DLY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic recog_i,
  output logic dack_o,
  output logic start_o
);

  logic                 ack_q;
  logic [START_DLY-1:0] dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q    <= 1'b0;
      dly_q[0] <= 1'b0;
    end else begin
      ack_q    <= recog_i;
      dly_q[0] <= recog_i;
    end
  end

  for (genvar i = 1; i < START_DLY; i++) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dly_q[i] <= 1'b0;
      else         dly_q[i] <= dly_q[i-1];
    end
  end

  assign dack_o  = ack_q;
  assign start_o = dly_q[START_DLY-1];

endmodule

// File: rtl/dreq_sampler.sv
module dreq_sampler #(
  parameter int unsigned START_DLY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dreq_ni,
  input  logic det_level_i,
  input  logic burst_i,
  input  logic bus_start_i,
  input  logic blk_done_i,
  output logic recog_o,
  output logic start_o,
  output logic dack_o
);

  logic cap, sync, prev, hit, recog;

  dreq_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (dreq_ni),
    .cap_o  (cap),
    .sync_o (sync),
    .prev_o (prev)
  );

  dreq_detect u_detect (
    .det_level_i (det_level_i),
    .cap_i       (cap),
    .sync_i      (sync),
    .prev_i      (prev),
    .hit_o       (hit)
  );

  dreq_arm_ctrl u_arm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit),
    .det_level_i (det_level_i),
    .burst_i     (burst_i),
    .bus_start_i (bus_start_i),
    .blk_done_i  (blk_done_i),
    .recog_o     (recog)
  );

  dreq_pulse_gen #(.START_DLY(START_DLY)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .recog_i (recog),
    .dack_o  (dack_o),
    .start_o (start_o)
  );

  assign recog_o = recog;

endmodule

// File: rtl/dreq_sampler_chk.sv
module dreq_sampler_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dreq_ni,
  input logic det_level_i,
  input logic burst_i,
  input logic bus_start_i,
  input logic blk_done_i,
  input logic recog_o,
  input logic start_o,
  input logic dack_o
);

  logic hold_q, wait_q, gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      wait_q <= 1'b0;
      gap_q  <= 1'b0;
    end else begin
      if (recog_o && burst_i && !det_level_i) hold_q <= 1'b1;
      else if (blk_done_i)                    hold_q <= 1'b0;
      if (recog_o && !(burst_i && !det_level_i)) wait_q <= 1'b1;
      else if (bus_start_i)                      wait_q <= 1'b0;
      gap_q <= wait_q & bus_start_i;
    end
  end

  p_recog_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recog_o |=> !recog_o);

  p_ack_after_recog_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recog_o |=> dack_o);

  p_ack_source_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> $past(recog_o));

  p_start_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  p_edge_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recog_o && !det_level_i) |-> ($past(dreq_ni, 3) && !$past(dreq_ni, 2)));

  p_level_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recog_o && det_level_i) |-> !$past(dreq_ni));

  p_burst_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q |-> !recog_o);

  p_rearm_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q || gap_q) |-> !recog_o);

endmodule

bind dreq_sampler dreq_sampler_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dreq_ni     (dreq_ni),
  .det_level_i (det_level_i),
  .burst_i     (burst_i),
  .bus_start_i (bus_start_i),
  .blk_done_i  (blk_done_i),
  .recog_o     (recog_o),
  .start_o     (start_o),
  .dack_o      (dack_o)
);

// File: tb/dreq_sampler_tb_top.sv
module dreq_sampler_tb_top;

  localparam int START_DLY = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic dreq_ni = 1'b1;
  logic det_level_i = 1'b0;
  logic burst_i = 1'b0;
  logic bus_start_i = 1'b0;
  logic blk_done_i = 1'b0;
  logic recog_o, start_o, dack_o;

  always #2 clk = ~clk;

  dreq_sampler #(.START_DLY(START_DLY)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .dreq_ni     (dreq_ni),
    .det_level_i (det_level_i),
    .burst_i     (burst_i),
    .bus_start_i (bus_start_i),
    .blk_done_i  (blk_done_i),
    .recog_o     (recog_o),
    .start_o     (start_o),
    .dack_o      (dack_o)
  );

  typedef struct {
    int         cyc;
    logic [2:0] ev;   // {recog, start, ack}
    string      tag;
  } exp_t;

  exp_t  sb_q[$];
  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  bit    run_mon = 1'b0;
  bit    done = 1'b0;
  string phase = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pop items due this cycle and compare
  always @(negedge clk) begin
    if (run_mon && rst_ni) begin
      logic [2:0] exp_v;
      logic [2:0] act_v;
      string      tag;
      exp_t       keep[$];
      exp_v = 3'b000;
      tag   = phase;
      keep  = {};
      foreach (sb_q[i]) begin
        if (sb_q[i].cyc == cyc) begin
          exp_v |= sb_q[i].ev;
          tag = sb_q[i].tag;
        end else if (sb_q[i].cyc < cyc) begin
          checks++; fails++;
          $display("FAIL %s missed event at cycle %0d: actual none expected %b",
                   sb_q[i].tag, sb_q[i].cyc, sb_q[i].ev);
        end else begin
          keep.push_back(sb_q[i]);
        end
      end
      sb_q = keep;
      act_v = {recog_o, start_o, dack_o};
      checks++;
      if (act_v !== exp_v) begin
        fails++;
        $display("FAIL %s cycle %0d {recog,start,ack}: actual %b expected %b",
                 tag, cyc, act_v, exp_v);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_req(int c, string tag);
    exp_t e;
    e.cyc = c;             e.ev = 3'b100; e.tag = tag;        sb_q.push_back(e);
    e.cyc = c + 1;         e.ev = 3'b001; e.tag = "R4 ack";   sb_q.push_back(e);
    e.cyc = c + START_DLY; e.ev = 3'b010; e.tag = "R5 start"; sb_q.push_back(e);
  endtask

  task automatic pulse_bus();
    bus_start_i = 1'b1;
    tick(1);
    bus_start_i = 1'b0;
  endtask

  task automatic pulse_done();
    blk_done_i = 1'b1;
    tick(1);
    blk_done_i = 1'b0;
  endtask

  initial begin
    int n;
    #1 rst_ni = 1'b0;
    tick(3);
    rst_ni = 1'b1;
    checks++;
    if ({recog_o, start_o, dack_o} !== 3'b000) begin
      fails++;
      $display("FAIL R1 reset outputs: actual %b expected 000", {recog_o, start_o, dack_o});
    end
    run_mon = 1'b1;
    phase = "R1 idle";
    tick(5);

    // level detection, cycle steal
    det_level_i = 1'b1;
    tick(2);
    phase = "R3";
    n = cyc; dreq_ni = 1'b0; expect_req(n + 1, "R3 level latency");
    tick(8);
    phase = "R6 blocked";
    tick(3);
    n = cyc; expect_req(n + 2, "R6 R9 rearm after bus start");
    pulse_bus();
    tick(8);
    dreq_ni = 1'b1;
    tick(2);
    phase = "R6 pin high after rearm";
    pulse_bus();
    tick(8);

    // edge detection, cycle steal
    det_level_i = 1'b0;
    tick(3);
    phase = "R2";
    n = cyc; dreq_ni = 1'b0; expect_req(n + 2, "R2 edge latency");
    tick(8);
    phase = "R8 edge while disarmed / steady low";
    dreq_ni = 1'b1;
    tick(3);
    dreq_ni = 1'b0;
    tick(4);
    pulse_bus();
    tick(8);
    dreq_ni = 1'b1;
    tick(3);
    n = cyc; dreq_ni = 1'b0; expect_req(n + 2, "R8 R2 fresh edge");
    tick(8);
    phase = "R8 rising edge";
    pulse_bus();
    tick(4);
    dreq_ni = 1'b1;
    tick(6);

    // edge detection, burst
    burst_i = 1'b1;
    tick(2);
    phase = "R7 one per block";
    n = cyc; dreq_ni = 1'b0; expect_req(n + 2, "R7 first edge");
    tick(6);
    for (int k = 0; k < 3; k++) begin
      pulse_bus();
      dreq_ni = 1'b1;
      tick(2);
      dreq_ni = 1'b0;
      tick(3);
    end
    pulse_done();
    dreq_ni = 1'b1;
    tick(3);
    n = cyc; dreq_ni = 1'b0; expect_req(n + 2, "R7 rearm after block done");
    tick(8);
    pulse_done();
    dreq_ni = 1'b1;
    tick(3);

    // level detection, burst
    det_level_i = 1'b1;
    tick(2);
    phase = "R9";
    n = cyc; dreq_ni = 1'b0; expect_req(n + 1, "R9 R3 level burst");
    tick(8);
    n = cyc; expect_req(n + 2, "R9 R6 repeat while low");
    pulse_bus();
    tick(8);
    dreq_ni = 1'b1;
    phase = "R9 pin high";
    pulse_bus();
    tick(8);

    run_mon = 1'b0;
    checks++;
    if (sb_q.size() != 0) begin
      fails++;
      $display("FAIL R4 R5 pending events: actual %0d expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog: actual hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule